// File: doc/BRIEF.md
# Nibble-Addressable Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit digital-to-analog converter. It keeps the code in two stages. Three 4-bit staging registers (low, middle and high nibble) can each be loaded on their own. A 12-bit output register holds the code that the converter sees. The output register takes a new value only on a transfer. A transfer copies all three staging nibbles at once, so the converter never sees a half-written code.

A host drives the block with an active-low chip select, an active-low write strobe, a 2-bit address and an 8-bit data bus. The block samples all of these on its own clock, and a write takes effect on the rising edge of the write strobe. A mode input selects the bus arrangement. In 4-bit mode each address reaches one nibble, or the transfer. In the two 8-bit modes the host uses two adjacent addresses. In both 8-bit modes, the second write loads the last byte and transfers the whole word in the same write. That transfer combines the bytes just written with the nibbles already staged.

Top module: `dac_nibreg`

## Requirements
- R1: After reset, `dac_code` reads 12'h000 and all three staging nibbles hold zero.
- R2: `dac_code` changes only on a transfer. Writes that only load staging nibbles leave it unchanged.
- R3: In mode 0 (4-bit bus), `data[3:0]` is loaded into the low nibble at address 0, the middle nibble at address 1 and the high nibble at address 2. Address 3 transfers `{high, middle, low}` to `dac_code` and loads nothing.
- R4: In mode 1 (8-bit, right-justified), address 2 loads `data[3:0]` into the low nibble and `data[7:4]` into the middle nibble. Address 1 loads `data[3:0]` into the high nibble and, in the same write, transfers using that new high nibble.
- R5: In mode 2 (8-bit, left-justified), address 2 loads `data[7:4]` into the low nibble. Address 1 loads `data[3:0]` into the middle nibble and `data[7:4]` into the high nibble, and transfers in the same write.
- R6: In modes 1 and 2, addresses 0 and 3 change neither the staging nibbles nor `dac_code`.
- R7: A write commits only when `wr_n` rises after a clock cycle in which `cs_n` and `wr_n` were both sampled low. It uses the address and data sampled in that last low cycle. A `wr_n` pulse with `cs_n` high has no effect.
- R8: The mode is taken only in cycles with no write in progress (`cs_n` or `wr_n` high). A change of `mode` while a write is low does not affect that write.
- R9: Mode 3 is reserved. Writes in this mode change neither the staging nibbles nor `dac_code`.
- R10: In the 8-bit modes, `dac_code` keeps its previous value between the first and the second byte write of an update. It never shows a mix of old and new bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| addr | input | 2 | Register address |
| data | input | 8 | Host write data |
| mode | input | 2 | Bus mode: 0 nibble, 1 byte right-justified, 2 byte left-justified, 3 reserved |
| dac_code | output | 12 | Code held for the converter |

## Verification
The checker assumes the host keeps `cs_n` low for the whole low phase of `wr_n`. It also assumes `wr_n` stays low for at least one clock, so that a commit always follows a sampled active cycle with a valid address and data. The stimulus meets these assumptions: every write holds the strobe low for one full clock, keeps select low until the strobe has risen, and leaves an idle clock between writes. Outside the deliberate mid-write change used to test R8, the mode is set during idle cycles.

// File: rtl/dac_nib_pkg.sv
`timescale 1ns/1ps
package dac_nib_pkg;
  typedef enum logic [1:0] {
    MODE_NIB4   = 2'd0,
    MODE_BYTE_R = 2'd1,
    MODE_BYTE_L = 2'd2,
    MODE_RSVD   = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/dac_nib_wrcap.sv
`timescale 1ns/1ps
// Samples the host strobes and flags a commit on the rising edge of wr_n.
module dac_nib_wrcap
  import dac_nib_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        mode,
  output logic              commit,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output bus_mode_e         mode_q
);
  logic active_now;
  logic active_q;
  logic wr_q;

  assign active_now = !cs_n && !wr_n;
  assign commit     = active_q && !wr_q && wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      wr_q     <= 1'b1;
      addr_q   <= '0;
      data_q   <= '0;
      mode_q   <= MODE_NIB4;
    end else begin
      active_q <= active_now;
      wr_q     <= wr_n;
      if (active_now) begin
        addr_q <= addr;
        data_q <= data;
      end else begin
        mode_q <= bus_mode_e'(mode);
      end
    end
  end
endmodule

// File: rtl/dac_nib_decode.sv
`timescale 1ns/1ps
// Turns a committed write into active-low nibble loads and a transfer strobe.
module dac_nib_decode
  import dac_nib_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic                  commit,
  input  bus_mode_e             mode_q,
  input  logic [1:0]            addr_q,
  input  logic [DATA_W-1:0]     data_q,
  output logic [2:0]            ld_n,
  output logic                  xfer_n,
  output logic [2:0][NIB_W-1:0] nib_data
);
  logic [NIB_W-1:0] lo_half;
  logic [NIB_W-1:0] hi_half;

  assign lo_half = data_q[NIB_W-1:0];
  assign hi_half = data_q[DATA_W-1:NIB_W];

  always_comb begin
    ld_n     = '1;
    xfer_n   = 1'b1;
    nib_data = {lo_half, lo_half, lo_half};
    if (commit) begin
      unique case (mode_q)
        MODE_NIB4: begin
          unique case (addr_q)
            2'd0: ld_n[0] = 1'b0;
            2'd1: ld_n[1] = 1'b0;
            2'd2: ld_n[2] = 1'b0;
            default: xfer_n = 1'b0;
          endcase
        end
        MODE_BYTE_R: begin
          if (addr_q == 2'd2) begin
            ld_n[0]     = 1'b0;
            ld_n[1]     = 1'b0;
            nib_data[0] = lo_half;
            nib_data[1] = hi_half;
          end else if (addr_q == 2'd1) begin
            ld_n[2]     = 1'b0;
            nib_data[2] = lo_half;
            xfer_n      = 1'b0;
          end
        end
        MODE_BYTE_L: begin
          if (addr_q == 2'd2) begin
            ld_n[0]     = 1'b0;
            nib_data[0] = hi_half;
          end else if (addr_q == 2'd1) begin
            ld_n[1]     = 1'b0;
            ld_n[2]     = 1'b0;
            nib_data[1] = lo_half;
            nib_data[2] = hi_half;
            xfer_n      = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_nib_latch.sv
`timescale 1ns/1ps
// One staging nibble; exposes its next value so a transfer can see new data.
module dac_nib_latch #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_n,
  input  logic [NIB_W-1:0] din,
  output logic [NIB_W-1:0] q_next
);
  logic [NIB_W-1:0] q;

  assign q_next = ld_n ? q : din;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/dac_nibreg.sv
`timescale 1ns/1ps
module dac_nibreg
  import dac_nib_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int NIB_CNT = 3,
  localparam int DATA_W  = 2 * NIB_W,
  localparam int CODE_W  = NIB_CNT * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        mode,
  output logic [CODE_W-1:0] dac_code
);
  logic                        commit;
  logic [1:0]                  addr_q;
  logic [DATA_W-1:0]           data_q;
  bus_mode_e                   mode_q;
  logic [NIB_CNT-1:0]          ld_n;
  logic                        xfer_n;
  logic [NIB_CNT-1:0][NIB_W-1:0] nib_data;
  logic [NIB_CNT-1:0][NIB_W-1:0] nib_next;

  dac_nib_wrcap #(.DATA_W(DATA_W), .ADDR_W(2)) u_wrcap (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .data   (data),
    .mode   (mode),
    .commit (commit),
    .addr_q (addr_q),
    .data_q (data_q),
    .mode_q (mode_q)
  );

  dac_nib_decode #(.NIB_W(NIB_W)) u_decode (
    .commit   (commit),
    .mode_q   (mode_q),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .ld_n     (ld_n),
    .xfer_n   (xfer_n),
    .nib_data (nib_data)
  );

  for (genvar g = 0; g < NIB_CNT; g++) begin : g_nib
    dac_nib_latch #(.NIB_W(NIB_W)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .ld_n   (ld_n[g]),
      .din    (nib_data[g]),
      .q_next (nib_next[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          dac_code <= '0;
    else if (!xfer_n) dac_code <= nib_next;
  end
endmodule

// File: rtl/dac_nibreg_chk.sv
`timescale 1ns/1ps
module dac_nibreg_chk
  import dac_nib_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        commit,
  input bus_mode_e   mode_q,
  input logic [1:0]  addr_q,
  input logic [2:0]  ld_n,
  input logic        xfer_n,
  input logic [11:0] dac_code
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (dac_code == 12'h000)); // R1
  AST_HOLD_NO_XFER: assert property (@(posedge clk) disable iff (rst) xfer_n |=> $stable(dac_code)); // R2
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst) !commit |-> ((&ld_n) && xfer_n)); // R7
  AST_BYTE_UNUSED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (commit && (mode_q != MODE_NIB4) && ((addr_q == 2'd0) || (addr_q == 2'd3))) |-> ((&ld_n) && xfer_n)); // R6
  AST_RSVD_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RSVD) |-> ((&ld_n) && xfer_n)); // R9
  AST_BYTE_XFER_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!xfer_n && (mode_q != MODE_NIB4)) |-> !ld_n[2]); // R4 R5
  AST_NIB4_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (commit && (mode_q == MODE_NIB4)) |-> ($countones({ld_n, xfer_n}) == 3)); // R3
endmodule

bind dac_nibreg dac_nibreg_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .commit   (commit),
  .mode_q   (mode_q),
  .addr_q   (addr_q),
  .ld_n     (ld_n),
  .xfer_n   (xfer_n),
  .dac_code (dac_code)
);

// File: tb/dac_nibreg_bench.sv
`timescale 1ns/1ps
module dac_nibreg_bench;
  typedef struct {
    logic [11:0] code;
    string       tag;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  data = 8'h00;
  logic [1:0]  mode = 2'd0;
  logic [11:0] dac_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  exp_item_t exp_q[$];
  event      sample_ev;

  logic [3:0]  m_lo = 4'h0, m_mi = 4'h0, m_hi = 4'h0;
  logic [11:0] m_out = 12'h000;

  always #2.5 clk = ~clk;

  dac_nibreg u_dac_nibreg (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .data     (data),
    .mode     (mode),
    .dac_code (dac_code)
  );

  // Reference model of a committed write, built from the requirements.
  task automatic model_write(input logic [1:0] m, input logic [1:0] a, input logic [7:0] d);
    case (m)
      2'd0: case (a)
        2'd0: m_lo = d[3:0];
        2'd1: m_mi = d[3:0];
        2'd2: m_hi = d[3:0];
        default: m_out = {m_hi, m_mi, m_lo};
      endcase
      2'd1: if (a == 2'd2) begin
        m_lo = d[3:0]; m_mi = d[7:4];
      end else if (a == 2'd1) begin
        m_hi = d[3:0]; m_out = {m_hi, m_mi, m_lo};
      end
      2'd2: if (a == 2'd2) begin
        m_lo = d[7:4];
      end else if (a == 2'd1) begin
        m_mi = d[3:0]; m_hi = d[7:4]; m_out = {m_hi, m_mi, m_lo};
      end
      default: ;
    endcase
  endtask

  // Driver: one host write, then an expected item for the monitor.
  task automatic bus_write(input logic [1:0] m, input logic [1:0] a, input logic [7:0] d,
                           input logic sel, input logic [1:0] m_during, input string tag);
    exp_item_t it;
    @(negedge clk);
    mode = m;
    @(negedge clk);
    cs_n = ~sel; wr_n = 1'b0; addr = a; data = d; mode = m_during;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    if (sel) model_write(m, a, d);
    it.code = m_out;
    it.tag  = tag;
    exp_q.push_back(it);
    -> sample_ev;
  endtask

  // Monitor: compares the output against the queue head after each write.
  initial begin
    exp_item_t it;
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        checks++;
        if (dac_code !== it.code) begin
          errors++;
          $display("FAIL %s: dac_code=%03h expected=%03h", it.tag, dac_code, it.code);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (dac_code !== 12'h000) begin
      errors++;
      $display("FAIL R1: dac_code=%03h expected=000", dac_code);
    end

    // Nibble mode: staging writes do not reach the output until transfer.
    bus_write(2'd0, 2'd0, 8'h05, 1'b1, 2'd0, "R2 low nibble only");
    bus_write(2'd0, 2'd1, 8'h0A, 1'b1, 2'd0, "R2 mid nibble only");
    bus_write(2'd0, 2'd2, 8'h03, 1'b1, 2'd0, "R2 high nibble only");
    bus_write(2'd0, 2'd3, 8'h00, 1'b1, 2'd0, "R3 nibble transfer");

    // Write with chip select high is ignored.
    bus_write(2'd0, 2'd0, 8'h0F, 1'b0, 2'd0, "R7 deselected write");
    bus_write(2'd0, 2'd3, 8'h00, 1'b1, 2'd0, "R7 staging untouched");

    // Right-justified bytes.
    bus_write(2'd1, 2'd2, 8'hC4, 1'b1, 2'd1, "R10 right first byte");
    bus_write(2'd1, 2'd1, 8'hF7, 1'b1, 2'd1, "R4 right second byte");
    bus_write(2'd1, 2'd0, 8'h11, 1'b1, 2'd1, "R6 right addr 0");
    bus_write(2'd1, 2'd3, 8'h22, 1'b1, 2'd1, "R6 right addr 3");
    bus_write(2'd1, 2'd1, 8'h09, 1'b1, 2'd1, "R6 low bytes kept");

    // Left-justified bytes.
    bus_write(2'd2, 2'd2, 8'h5A, 1'b1, 2'd2, "R10 left first byte");
    bus_write(2'd2, 2'd1, 8'hB6, 1'b1, 2'd2, "R5 left second byte");
    bus_write(2'd2, 2'd0, 8'hEE, 1'b1, 2'd2, "R6 left addr 0");

    // Reserved mode.
    bus_write(2'd3, 2'd1, 8'hFF, 1'b1, 2'd3, "R9 reserved addr 1");
    bus_write(2'd3, 2'd2, 8'hFF, 1'b1, 2'd3, "R9 reserved addr 2");
    bus_write(2'd3, 2'd0, 8'hFF, 1'b1, 2'd3, "R9 reserved addr 0");
    bus_write(2'd0, 2'd3, 8'h00, 1'b1, 2'd0, "R9 staging untouched");

    // Mode changed during the low phase: the earlier mode applies.
    bus_write(2'd1, 2'd2, 8'h3C, 1'b1, 2'd2, "R8 mode change mid write");
    bus_write(2'd2, 2'd1, 8'h21, 1'b1, 2'd2, "R8 earlier mode used");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule